// File: doc/BRIEF.md
# MMU Exception Entry Controller

This block sits beside a data-side address translation unit. For each data access it decides whether a translation fault has to be taken. There are two outcomes. A *miss* means relocation is on and no translation entry matched. An *error* means an entry matched but the access may not go ahead. On either outcome the block captures the processor state on exception entry in a single clock edge. The faulting effective address goes into save register 0. A filtered copy of the low half of the machine state word goes into save register 1. A rewritten machine state word and a redirect address are produced for the fetch logic.

Requests are presented one per cycle with `req_valid` high. The block has three states. In `XS_IDLE` no exception is in flight. In `XS_MISS` a miss pulse is shown for one cycle. In `XS_ERR` an error pulse is shown for one cycle. The transitions are:
- Any state goes to `XS_MISS` when the current request classifies as a miss.
- Any state goes to `XS_ERR` when the current request classifies as an error.
- Any state goes to `XS_IDLE` when the current request classifies as neither.

Because every state takes the same transitions, back-to-back faults produce back-to-back pulses. Machine state bit positions below are given as LSB-first indices into the 32-bit word: LE=0, RI=1, DR=4, IP=6, ME=12, ILE=16. Access kind codes are load=0, store=1, instruction-block invalidate=2, data-block zero=3, data-block clean=4, data-block flush=5, data-block invalidate=6, reserved=7.

Top module: `mmu_xent_top`

## Requirements
- R1: A request with `msr_cur[4]`=1 and `tlb_hit`=0 raises `miss_taken` and `taken` for exactly the following cycle. With `msr_cur[4]`=0 no exception is raised at all.
- R2: A request that hits, with relocation on and access kind 0..6, raises an error when `seg_valid`=0 or `page_valid`=0.
- R3: A hitting request with relocation on and access kind 0..6 raises an error when `prot_viol`=1.
- R4: A hitting store (1) or data-block zero (3) with `page_changed`=0 raises an error. Any other kind with `page_changed`=0 and no other fault raises nothing.
- R5: When `tlb_hit`=0 the outcome is a miss, whatever the valid, protection and change inputs say.
- R6: Access kind 7 and requests with `req_valid`=0 raise nothing and leave `srr0_q`, `srr1_q` and `msr_new` unchanged.
- R7: On exception entry `srr0_q` becomes `fault_ea`.
- R8: On exception entry `srr1_q[15:0]` becomes `msr_cur[15:0]`, except bit 1, and `srr1_q[31:16]` becomes 0.
- R9: `srr1_q[1]` is never cleared by exception entry. Entry leaves it set if it was set and sets it if `msr_cur[1]`=1. It is cleared only when `msr_load`=1 with `msr_cur[1]`=0 and no exception is taken in that cycle.
- R10: On entry `msr_new` keeps `msr_cur` bits 6 and 12, takes bit 0 from `msr_cur[16]`, and has every other bit at 0.
- R11: `redirect_pc` is the base plus 0x1200 for a miss and the base plus 0x1400 for an error. The base is 0x00000000 when `msr_cur[6]`=0 and 0xFFF00000 when it is 1. `redirect_pc` is 0 while `taken` is low.
- R12: Reset clears every output to 0. `miss_taken` and `err_taken` are never high together, and `taken` is their OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A data access is presented this cycle |
| tlb_hit | input | 1 | Lookup found a matching entry |
| seg_valid | input | 1 | Segment valid bit of the matched entry |
| page_valid | input | 1 | Page valid bit of the matched entry |
| prot_viol | input | 1 | Access breaks storage protection |
| page_changed | input | 1 | Change bit of the matched page |
| acc_kind | input | 3 | Access kind code |
| msr_cur | input | 32 | Current machine state word |
| msr_load | input | 1 | Machine state word was loaded by software this cycle |
| fault_ea | input | 32 | Effective address of the accessing instruction |
| taken | output | 1 | Exception entry pulse |
| miss_taken | output | 1 | Entry was a miss |
| err_taken | output | 1 | Entry was an error |
| redirect_pc | output | 32 | Handler address, valid with `taken` |
| srr0_q | output | 32 | Save register 0 |
| srr1_q | output | 32 | Save register 1 |
| msr_new | output | 32 | Machine state word to install on entry |

## Verification
A state register stuck in or wrongly entering `XS_MISS` or `XS_ERR` shows at the ports in the first cycle after the request. It appears as a missing, extra or wrongly typed pulse, and as a redirect offset of 0x1200 where 0x1400 was due, or the reverse. A corrupted save or machine state register shows on `srr0_q`, `srr1_q` or `msr_new` in that same cycle. It stays visible until the next entry, because those registers hold between faults. The sticky bit 1 of save register 1 is the only state that outlives an entry. The scoreboard therefore walks it through set, held-over-entry, load-with-one and load-with-zero steps, and checks it after each one.

// File: rtl/mmu_xent_pkg.sv
package mmu_xent_pkg;

    typedef enum logic [2:0] {
        ACC_LOAD       = 3'd0,
        ACC_STORE      = 3'd1,
        ACC_IBLK_INV   = 3'd2,
        ACC_DBLK_ZERO  = 3'd3,
        ACC_DBLK_CLEAN = 3'd4,
        ACC_DBLK_FLUSH = 3'd5,
        ACC_DBLK_INV   = 3'd6,
        ACC_RSVD       = 3'd7
    } acc_kind_e;

    typedef enum logic [1:0] {
        FK_NONE = 2'd0,
        FK_MISS = 2'd1,
        FK_ERR  = 2'd2
    } fault_kind_e;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_MISS = 2'd1,
        XS_ERR  = 2'd2
    } xent_state_e;

    // machine state bit indices, LSB first
    localparam int MB_LE  = 0;
    localparam int MB_RI  = 1;
    localparam int MB_DR  = 4;
    localparam int MB_IP  = 6;
    localparam int MB_ME  = 12;
    localparam int MB_ILE = 16;

endpackage

// File: rtl/xent_classify.sv
module xent_classify
    import mmu_xent_pkg::*;
(
    input  logic        req_valid,
    input  logic        reloc_on,
    input  logic        tlb_hit,
    input  logic        seg_valid,
    input  logic        page_valid,
    input  logic        prot_viol,
    input  logic        page_changed,
    input  logic [2:0]  acc_kind,
    output fault_kind_e kind
);
    logic kind_ok;
    logic is_write;
    logic bad_entry;

    always_comb begin
        kind_ok   = (acc_kind != ACC_RSVD);
        is_write  = (acc_kind == ACC_STORE) || (acc_kind == ACC_DBLK_ZERO);
        bad_entry = !seg_valid || !page_valid || prot_viol || (is_write && !page_changed);
        kind      = FK_NONE;
        if (req_valid && reloc_on && kind_ok) begin
            if (!tlb_hit) begin
                kind = FK_MISS;            // miss wins over any entry flag
            end else if (bad_entry) begin
                kind = FK_ERR;
            end
        end
    end

endmodule

// File: rtl/xent_image.sv
module xent_image
    import mmu_xent_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int HALF = XLEN / 2
) (
    input  logic [HALF:0]   msr_lo,
    input  logic            sticky_old,
    output logic [XLEN-1:0] srr1_img,
    output logic [XLEN-1:0] msr_img
);
    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        if (i == MB_RI) begin : g_sticky
            assign srr1_img[i] = sticky_old | msr_lo[i];
        end else if (i < HALF) begin : g_copy
            assign srr1_img[i] = msr_lo[i];
        end else begin : g_zero
            assign srr1_img[i] = 1'b0;
        end

        if (i == MB_LE) begin : g_le
            assign msr_img[i] = msr_lo[MB_ILE];
        end else if (i == MB_IP || i == MB_ME) begin : g_keep
            assign msr_img[i] = msr_lo[i];
        end else begin : g_clr
            assign msr_img[i] = 1'b0;
        end
    end

endmodule

// File: rtl/xent_seq.sv
module xent_seq
    import mmu_xent_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] HI_BASE  = 32'hFFF0_0000,
    parameter logic [ADDR_W-1:0] MISS_OFS = 32'h0000_1200,
    parameter logic [ADDR_W-1:0] ERR_OFS  = 32'h0000_1400
) (
    input  logic              clk,
    input  logic              rst,
    input  fault_kind_e       kind,
    input  logic              msr_load,
    input  logic              ri_bit,
    input  logic              ip_bit,
    input  logic [ADDR_W-1:0] fault_ea,
    input  logic [XLEN-1:0]   srr1_img,
    input  logic [XLEN-1:0]   msr_img,
    output logic              taken,
    output logic              miss_taken,
    output logic              err_taken,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic [ADDR_W-1:0] srr0_q,
    output logic [XLEN-1:0]   srr1_q,
    output logic [XLEN-1:0]   msr_new
);
    xent_state_e       state_q, state_d;
    logic              hi_q;
    logic [ADDR_W-1:0] base;

    always_comb begin
        unique case (kind)
            FK_MISS: state_d = XS_MISS;
            FK_ERR:  state_d = XS_ERR;
            default: state_d = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= XS_IDLE;
            hi_q    <= 1'b0;
            srr0_q  <= '0;
            srr1_q  <= '0;
            msr_new <= '0;
        end else begin
            state_q <= state_d;
            if (kind != FK_NONE) begin
                hi_q    <= ip_bit;
                srr0_q  <= fault_ea;
                srr1_q  <= srr1_img;
                msr_new <= msr_img;
            end else if (msr_load && !ri_bit) begin
                srr1_q[MB_RI] <= 1'b0;
            end
        end
    end

    always_comb begin
        base        = hi_q ? HI_BASE : '0;
        taken       = 1'b0;
        miss_taken  = 1'b0;
        err_taken   = 1'b0;
        redirect_pc = '0;
        unique case (state_q)
            XS_MISS: begin
                taken       = 1'b1;
                miss_taken  = 1'b1;
                redirect_pc = base + MISS_OFS;
            end
            XS_ERR: begin
                taken       = 1'b1;
                err_taken   = 1'b1;
                redirect_pc = base + ERR_OFS;
            end
            default: ;
        endcase
    end

    assert_kind_onehot_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({miss_taken, err_taken}));

    assert_miss_offset_R11: assert property (@(posedge clk) disable iff (rst)
        miss_taken |-> (redirect_pc[15:0] == MISS_OFS[15:0]));

    assert_err_offset_R11: assert property (@(posedge clk) disable iff (rst)
        err_taken |-> (redirect_pc[15:0] == ERR_OFS[15:0]));

    assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (srr1_q[MB_RI] && !msr_load) |=> srr1_q[MB_RI]);

endmodule

// File: rtl/mmu_xent_top.sv
module mmu_xent_top
    import mmu_xent_pkg::*;
#(
    parameter int                XLEN     = 32,
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] HI_BASE  = 32'hFFF0_0000,
    parameter logic [ADDR_W-1:0] MISS_OFS = 32'h0000_1200,
    parameter logic [ADDR_W-1:0] ERR_OFS  = 32'h0000_1400
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              tlb_hit,
    input  logic              seg_valid,
    input  logic              page_valid,
    input  logic              prot_viol,
    input  logic              page_changed,
    input  logic [2:0]        acc_kind,
    input  logic [XLEN-1:0]   msr_cur,
    input  logic              msr_load,
    input  logic [ADDR_W-1:0] fault_ea,
    output logic              taken,
    output logic              miss_taken,
    output logic              err_taken,
    output logic [ADDR_W-1:0] redirect_pc,
    output logic [ADDR_W-1:0] srr0_q,
    output logic [XLEN-1:0]   srr1_q,
    output logic [XLEN-1:0]   msr_new
);
    localparam int HALF = XLEN / 2;

    fault_kind_e     kind;
    logic [XLEN-1:0] srr1_img;
    logic [XLEN-1:0] msr_img;

    xent_classify u_classify (
        .req_valid    (req_valid),
        .reloc_on     (msr_cur[MB_DR]),
        .tlb_hit      (tlb_hit),
        .seg_valid    (seg_valid),
        .page_valid   (page_valid),
        .prot_viol    (prot_viol),
        .page_changed (page_changed),
        .acc_kind     (acc_kind),
        .kind         (kind)
    );

    xent_image #(.XLEN(XLEN)) u_image (
        .msr_lo     (msr_cur[HALF:0]),
        .sticky_old (srr1_q[MB_RI]),
        .srr1_img   (srr1_img),
        .msr_img    (msr_img)
    );

    xent_seq #(
        .XLEN     (XLEN),
        .ADDR_W   (ADDR_W),
        .HI_BASE  (HI_BASE),
        .MISS_OFS (MISS_OFS),
        .ERR_OFS  (ERR_OFS)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .kind        (kind),
        .msr_load    (msr_load),
        .ri_bit      (msr_cur[MB_RI]),
        .ip_bit      (msr_cur[MB_IP]),
        .fault_ea    (fault_ea),
        .srr1_img    (srr1_img),
        .msr_img     (msr_img),
        .taken       (taken),
        .miss_taken  (miss_taken),
        .err_taken   (err_taken),
        .redirect_pc (redirect_pc),
        .srr0_q      (srr0_q),
        .srr1_q      (srr1_q),
        .msr_new     (msr_new)
    );

    assert_miss_follows_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && msr_cur[MB_DR] && !tlb_hit && acc_kind != ACC_RSVD) |=> miss_taken);

    assert_no_reloc_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (!msr_cur[MB_DR] || !req_valid) |=> !taken);

    assert_srr0_capture_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && msr_cur[MB_DR] && !tlb_hit && acc_kind != ACC_RSVD) |=> (srr0_q == $past(fault_ea)));

    assert_msr_rewrite_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && msr_cur[MB_DR] && !tlb_hit && acc_kind != ACC_RSVD) |=>
        (msr_new == (($past(msr_cur) & ((XLEN'(1) << MB_IP) | (XLEN'(1) << MB_ME)))
                     | XLEN'($past(msr_cur[MB_ILE])))));

endmodule

// File: tb/mmu_xent_top_tb_top.sv
`timescale 1ns/1ps
module mmu_xent_top_tb_top;

    typedef struct {
        logic        tk;
        logic        ms;
        logic        er;
        logic [31:0] pc;
        logic [31:0] s0;
        logic [31:0] s1;
        logic [31:0] mn;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, tlb_hit = 1'b0, seg_valid = 1'b1, page_valid = 1'b1;
    logic        prot_viol = 1'b0, page_changed = 1'b1, msr_load = 1'b0;
    logic [2:0]  acc_kind = 3'd0;
    logic [31:0] msr_cur = '0, fault_ea = '0;
    logic        taken, miss_taken, err_taken;
    logic [31:0] redirect_pc, srr0_q, srr1_q, msr_new;

    exp_t        sb_q[$];
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;
    logic [31:0] m_s0 = '0, m_s1 = '0, m_mn = '0;

    always #2.5 clk = ~clk;

    mmu_xent_top dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .tlb_hit(tlb_hit),
        .seg_valid(seg_valid), .page_valid(page_valid), .prot_viol(prot_viol),
        .page_changed(page_changed), .acc_kind(acc_kind), .msr_cur(msr_cur),
        .msr_load(msr_load), .fault_ea(fault_ea), .taken(taken),
        .miss_taken(miss_taken), .err_taken(err_taken), .redirect_pc(redirect_pc),
        .srr0_q(srr0_q), .srr1_q(srr1_q), .msr_new(msr_new)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // driver: apply one request and push its expected outcome
    task automatic apply(input string tag, input logic v, input logic hit, input logic sg,
                         input logic pg, input logic pv, input logic ch, input logic [2:0] k,
                         input logic [31:0] msr, input logic ld, input logic [31:0] ea);
        exp_t e;
        logic miss, err, wr;
        @(negedge clk);
        req_valid = v; tlb_hit = hit; seg_valid = sg; page_valid = pg;
        prot_viol = pv; page_changed = ch; acc_kind = k; msr_cur = msr;
        msr_load = ld; fault_ea = ea;
        wr   = (k == 3'd1) || (k == 3'd3);
        miss = v && msr[4] && (k != 3'd7) && !hit;
        err  = v && msr[4] && (k != 3'd7) && hit && (!sg || !pg || pv || (wr && !ch));
        if (miss || err) begin
            m_s0 = ea;
            m_s1 = {16'h0, msr[15:2], m_s1[1] | msr[1], msr[0]};
            m_mn = (msr & 32'h0000_1040) | {31'h0, msr[16]};
        end else if (ld && !msr[1]) begin
            m_s1[1] = 1'b0;
        end
        e.tk = miss || err; e.ms = miss; e.er = err;
        e.pc = !(miss || err) ? 32'h0 :
               ((msr[6] ? 32'hFFF0_0000 : 32'h0) + (miss ? 32'h1200 : 32'h1400));
        e.s0 = m_s0; e.s1 = m_s1; e.mn = m_mn; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: compare one expected item after each clock edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() != 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk({e.tag, " taken"}, {31'h0, taken}, {31'h0, e.tk});
            chk({e.tag, " miss"},  {31'h0, miss_taken}, {31'h0, e.ms});
            chk({e.tag, " err"},   {31'h0, err_taken}, {31'h0, e.er});
            chk({e.tag, " pc"},    redirect_pc, e.pc);
            chk({e.tag, " srr0"},  srr0_q, e.s0);
            chk({e.tag, " srr1"},  srr1_q, e.s1);
            chk({e.tag, " msr"},   msr_new, e.mn);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL R12 watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R12 reset taken", {31'h0, taken}, 32'h0);
        chk("R12 reset pc", redirect_pc, 32'h0);
        chk("R12 reset srr1", srr1_q, 32'h0);
        chk("R12 reset msr", msr_new, 32'h0);
        @(negedge clk) rst = 1'b0;
        //            tag            v hit sg pg pv ch k     msr           ld ea
        apply("R1 miss",             1, 0, 1, 1, 0, 1, 3'd0, 32'h0000_0010, 0, 32'h1000_0004);
        apply("R1 reloc off",        1, 0, 1, 1, 0, 1, 3'd1, 32'h0000_0000, 0, 32'h1000_0008);
        apply("R2 seg invalid",      1, 1, 0, 1, 0, 1, 3'd0, 32'h0000_1011, 0, 32'h2000_0000);
        apply("R2 page invalid",     1, 1, 1, 0, 0, 1, 3'd6, 32'h0001_0010, 0, 32'h2000_0010);
        apply("R2 clean ok",         1, 1, 1, 1, 0, 1, 3'd4, 32'h0000_0010, 0, 32'h2000_0020);
        apply("R3 protection",       1, 1, 1, 1, 1, 1, 3'd2, 32'h0000_0050, 0, 32'h3000_0000);
        apply("R4 store clean page", 1, 1, 1, 1, 0, 0, 3'd1, 32'h0000_8010, 0, 32'h4000_0000);
        apply("R4 load clean page",  1, 1, 1, 1, 0, 0, 3'd0, 32'h0000_0010, 0, 32'h4000_0004);
        apply("R4 zero clean page",  1, 1, 1, 1, 0, 0, 3'd3, 32'h0000_0010, 0, 32'h4000_0008);
        apply("R4 flush clean page", 1, 1, 1, 1, 0, 0, 3'd5, 32'h0000_0010, 0, 32'h4000_000C);
        apply("R5 miss priority",    1, 0, 0, 0, 1, 0, 3'd1, 32'h0000_0010, 0, 32'h5000_0000);
        apply("R6 reserved kind",    1, 0, 0, 1, 1, 0, 3'd7, 32'h0000_0010, 0, 32'h6000_0000);
        apply("R6 no request",       0, 0, 0, 0, 1, 0, 3'd1, 32'h0000_0010, 0, 32'h6000_0004);
        apply("R11 high base miss",  1, 0, 1, 1, 0, 1, 3'd0, 32'hFFFF_FFFD, 0, 32'h7000_0000);
        apply("R11 high base err",   1, 1, 1, 1, 1, 1, 3'd0, 32'h0001_1050, 0, 32'h7000_0004);
        apply("R8 R10 pattern",      1, 0, 1, 1, 0, 1, 3'd4, 32'hA5A5_5A5D, 0, 32'h7000_0008);
        apply("R9 set sticky",       1, 0, 1, 1, 0, 1, 3'd0, 32'h0000_0012, 0, 32'h8000_0000);
        apply("R9 entry keeps",      1, 1, 0, 1, 0, 1, 3'd0, 32'h0000_0010, 0, 32'h8000_0004);
        apply("R9 load one keeps",   0, 0, 1, 1, 0, 1, 3'd0, 32'h0000_0002, 1, 32'h8000_0008);
        apply("R9 load zero clears", 0, 0, 1, 1, 0, 1, 3'd0, 32'h0000_0000, 1, 32'h8000_000C);
        apply("R9 entry after clear",1, 0, 1, 1, 0, 1, 3'd0, 32'h0000_0010, 0, 32'h8000_0010);
        apply("R12 idle",            0, 0, 1, 1, 0, 1, 3'd0, 32'h0000_0000, 0, 32'h0);
        repeat (3) @(posedge clk);
        #2;
        finish_run();
    end

endmodule